// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer behind a small register bus. Software must keep writing a refresh key to the counter register. If it stops, the counter climbs on each tick-enable pulse until it reaches the programmed timeout. The block then raises a reset request for one clock cycle.

The control and timeout registers are guarded. A write to either one takes effect only after software has placed the unlock key in the counter register. Each accepted configuration write relocks the block, and the window also closes by itself after a fixed number of clocks. A mode bit sets how keys arrive: either as one 32-bit word, or as two 16-bit halves written one after the other, low half first.

The bus is plain, with no back-pressure. A write completes in the cycle its strobe is high. Read data is registered and valid in the cycle after the read strobe. Tick-enable pulses come from an external clock generator, and the clock select field is driven out so that this generator can pick its source.

Top module: `wdt_keyguard`

## Requirements
- R1: After reset the control word (word address 0) reads 0x000000A0: enable (bit 7) and reconfiguration permit (bit 5) set, all other bits clear. The timeout (word address 2) reads 0x0000FFFF, the counter (word address 1) reads 0, and the reset request is low.
- R2: While the block is locked, writes to control or timeout change nothing.
- R3: With bit 13 clear, writing 0xC520 and then 0xD928 (low 16 bits) to the counter register sets the unlocked flag, bit 11. Any other value written to the counter register between the two halves aborts the sequence.
- R4: With bit 13 set, a single write of 0xD928C520 unlocks the block. The two 16-bit halves on their own do not.
- R5: When a write to control or timeout is accepted, the reconfiguration-complete flag (bit 10) is set and the unlocked flag clears. Bit 10 clears again on the next successful unlock.
- R6: If no configuration write follows, the unlocked flag clears 255 clock cycles after the unlock. Later configuration writes are then ignored.
- R7: A refresh key clears the counter to 0. The key is 0xB480A602 in 32-bit mode, or 0xA602 followed by 0xB480 in 16-bit mode.
- R8: While enabled, the counter rises by 1 on each tick-enable pulse and holds once it reaches the timeout. When enable is 0, the counter is held at 0.
- R9: When the counter is at or above the timeout, the reset request goes high for exactly one cycle. It does not go high again until a refresh occurs.
- R10: If bit 1 is clear, the counter does not advance while the wait input is high. If bit 0 is clear, the counter does not advance while the stop input is high.
- R11: After a configuration with bit 5 clear has been applied, every later unlock is refused until reset.
- R12: The clock select output follows control bits 9:8.
- R13: Read data is registered and appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Word address: 0 control, 1 counter, 2 timeout |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Counter tick pulse from the clock generator |
| sys_wait | input | 1 | System is in wait mode |
| sys_stop | input | 1 | System is in stop mode |
| clk_sel | output | 2 | Tick source select for the clock generator |
| wdog_rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest states to reach from the ports are the expiry of the unlock window and the permanent lockout. The bench reaches the first by idling for well over 255 cycles after an unlock, then issuing a configuration write that must not land. It reaches the second by committing a control word with the permit bit clear and then presenting a correct 32-bit unlock that must fail. Aborted half-key sequences and random non-key writes mixed into random tick runs show that only exact, ordered keys affect the counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [31:0] KEY_UNLOCK32 = 32'hD928_C520;
  localparam logic [31:0] KEY_REFRESH32 = 32'hB480_A602;
  localparam logic [15:0] KEY_UNLOCK_LO = 16'hC520;
  localparam logic [15:0] KEY_UNLOCK_HI = 16'hD928;
  localparam logic [15:0] KEY_REFRESH_LO = 16'hA602;
  localparam logic [15:0] KEY_REFRESH_HI = 16'hB480;

  localparam int BIT_MODE32 = 13;
  localparam int BIT_OPEN = 11;
  localparam int BIT_DONE = 10;
  localparam int BIT_SEL_HI = 9;
  localparam int BIT_SEL_LO = 8;
  localparam int BIT_EN = 7;
  localparam int BIT_PERMIT = 5;
  localparam int BIT_WAIT = 1;
  localparam int BIT_STOP = 0;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_CNT = 2'd1;
  localparam logic [1:0] ADR_TOV = 2'd2;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_UNLK_LO,
    KS_REF_LO
  } key_st_e;

  typedef struct packed {
    logic       mode32;
    logic [1:0] sel;
    logic       en;
    logic       permit;
    logic       run_wait;
    logic       run_stop;
  } ctrl_t;
endpackage

// File: rtl/wdt_keydec.sv
module wdt_keydec
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic [31:0] wdata,
  input  logic        mode32,
  output logic        unlock_p,
  output logic        refresh_p
);
  key_st_e st_q, st_d;
  logic [15:0] lo;

  assign lo = wdata[15:0];

  always_comb begin
    st_d = st_q;
    unlock_p = 1'b0;
    refresh_p = 1'b0;
    if (wr_cmd) begin
      if (mode32) begin
        st_d = KS_IDLE;
        unlock_p = (wdata == KEY_UNLOCK32);
        refresh_p = (wdata == KEY_REFRESH32);
      end else begin
        case (st_q)
          KS_UNLK_LO: begin
            unlock_p = (lo == KEY_UNLOCK_HI);
            st_d = KS_IDLE;
          end
          KS_REF_LO: begin
            refresh_p = (lo == KEY_REFRESH_HI);
            st_d = KS_IDLE;
          end
          default: begin
            if (lo == KEY_UNLOCK_LO) st_d = KS_UNLK_LO;
            else if (lo == KEY_REFRESH_LO) st_d = KS_REF_LO;
            else st_d = KS_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else st_q <= st_d;
  end

  // R3: a 16-bit key pulse only follows a first half recorded earlier
  a_r3_half_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !mode32 && st_q == KS_IDLE) |-> !(unlock_p || refresh_p));
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int TO_W = 32,
  parameter int WIN = 255,
  parameter logic [TO_W-1:0] TO_RST = TO_W'(32'hFFFF)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_tov,
  input  logic [31:0]     wdata,
  input  logic            unlock_p,
  output ctrl_t           ctrl,
  output logic [TO_W-1:0] toval,
  output logic            unlocked,
  output logic            done
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0] win_q;
  logic applied_q;
  logic lockout;
  logic cfg_hit;

  assign lockout = applied_q && !ctrl.permit;
  assign cfg_hit = unlocked && (wr_ctrl || wr_tov);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '{mode32: 1'b0, sel: 2'd0, en: 1'b1, permit: 1'b1,
                run_wait: 1'b0, run_stop: 1'b0};
      toval <= TO_RST;
      unlocked <= 1'b0;
      done <= 1'b0;
      applied_q <= 1'b0;
      win_q <= '0;
    end else if (unlock_p && !lockout) begin
      unlocked <= 1'b1;
      done <= 1'b0;
      win_q <= WIN_W'(WIN);
    end else if (cfg_hit) begin
      if (wr_ctrl) begin
        ctrl.mode32 <= wdata[BIT_MODE32];
        ctrl.sel <= wdata[BIT_SEL_HI:BIT_SEL_LO];
        ctrl.en <= wdata[BIT_EN];
        ctrl.permit <= wdata[BIT_PERMIT];
        ctrl.run_wait <= wdata[BIT_WAIT];
        ctrl.run_stop <= wdata[BIT_STOP];
      end else begin
        toval <= wdata[TO_W-1:0];
      end
      done <= 1'b1;
      unlocked <= 1'b0;
      applied_q <= 1'b1;
      win_q <= '0;
    end else if (unlocked) begin
      if (win_q == WIN_W'(1)) unlocked <= 1'b0;
      win_q <= win_q - 1'b1;
    end
  end

  a_r2_locked_tov: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !unlock_p && wr_tov) |=> $stable(toval));
  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (!unlocked && done));
  a_r6_window_live: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> (win_q != '0));
  a_r11_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && !unlocked) |=> !unlocked);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             run_ok,
  input  logic             refresh_p,
  input  logic [CNT_W-1:0] toval,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req
);
  logic fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      fired_q <= 1'b0;
      rst_req <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      fired_q <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (refresh_p) begin
        cnt <= '0;
        fired_q <= 1'b0;
      end else if (cnt >= toval) begin
        if (!fired_q) begin
          rst_req <= 1'b1;
          fired_q <= 1'b1;
        end
      end else if (tick && run_ok) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r7_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && refresh_p) |=> (cnt == '0));
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !refresh_p && tick && run_ok && cnt < toval) |=> (cnt == $past(cnt) + 1'b1));
  a_r8_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int WIN = 255
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        tick_en,
  input  logic        sys_wait,
  input  logic        sys_stop,
  output logic [1:0]  clk_sel,
  output logic        wdog_rst_req
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] toval;
  logic [CNT_W-1:0] cnt;
  logic unlocked, done, unlock_p, refresh_p, run_ok;
  logic [31:0] ctrl_word;

  wdt_keydec u_key (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd(wr_en && addr == ADR_CNT), .wdata(wdata), .mode32(ctrl.mode32),
    .unlock_p(unlock_p), .refresh_p(refresh_p)
  );

  wdt_cfg #(.TO_W(CNT_W), .WIN(WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_en && addr == ADR_CTRL), .wr_tov(wr_en && addr == ADR_TOV),
    .wdata(wdata), .unlock_p(unlock_p),
    .ctrl(ctrl), .toval(toval), .unlocked(unlocked), .done(done)
  );

  assign run_ok = !(sys_wait && !ctrl.run_wait) && !(sys_stop && !ctrl.run_stop);

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .tick(tick_en), .run_ok(run_ok),
    .refresh_p(refresh_p), .toval(toval), .cnt(cnt), .rst_req(wdog_rst_req)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_MODE32] = ctrl.mode32;
    ctrl_word[BIT_OPEN] = unlocked;
    ctrl_word[BIT_DONE] = done;
    ctrl_word[BIT_SEL_HI:BIT_SEL_LO] = ctrl.sel;
    ctrl_word[BIT_EN] = ctrl.en;
    ctrl_word[BIT_PERMIT] = ctrl.permit;
    ctrl_word[BIT_WAIT] = ctrl.run_wait;
    ctrl_word[BIT_STOP] = ctrl.run_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADR_CTRL: rdata <= ctrl_word;
        ADR_CNT:  rdata <= 32'(cnt);
        ADR_TOV:  rdata <= 32'(toval);
        default:  rdata <= '0;
      endcase
    end
  end

  assign clk_sel = ctrl.sel;

  a_r12_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_CTRL && unlocked) |=> (clk_sel == $past(wdata[BIT_SEL_HI:BIT_SEL_LO])));
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_wdt_keyguard.sv
module sim_wdt_keyguard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic tick_en = 1'b0, sys_wait = 1'b0, sys_stop = 1'b0;
  logic [1:0] clk_sel;
  logic wdog_rst_req;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int run_hi = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wdt_keyguard u0 (.*);

  always @(negedge clk) begin
    if (wdog_rst_req) begin
      pulses++;
      run_hi++;
      if (run_hi > 1) begin
        checks++; fails++;
        $display("FAIL R9 reset request high for %0d cycles, expected 1", run_hi);
      end
    end else run_hi = 0;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic unlock16(); wr(2'd1, 32'hC520); wr(2'd1, 32'hD928); endtask
  task automatic refresh16(); wr(2'd1, 32'hA602); wr(2'd1, 32'hB480); endtask

  function automatic int exp_cnt(input int n, input int lim);
    return (n < lim) ? n : lim;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k, exp_p;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0000_00A0);
    rd(2'd2, v); chk("R1 toval", v, 32'h0000_FFFF);
    rd(2'd1, v); chk("R1 cnt", v, 0);
    chk("R1 rst_req", {31'b0, wdog_rst_req}, 0);

    // R2 locked writes ignored
    wr(2'd2, 32'd5); rd(2'd2, v); chk("R2 toval locked", v, 32'hFFFF);
    wr(2'd0, 32'h0); rd(2'd0, v); chk("R2 ctrl locked", v, 32'hA0);

    // R3 aborted half sequence, then valid one
    wr(2'd1, 32'hC520); wr(2'd1, 32'h1234); wr(2'd1, 32'hD928);
    rd(2'd0, v); chk("R3 abort", v, 32'hA0);
    unlock16(); rd(2'd0, v); chk("R3 unlocked", v, 32'h8A0);

    // R5 accepted write relocks, sets done
    wr(2'd2, 32'd20); rd(2'd2, v); chk("R5 toval", v, 32'd20);
    rd(2'd0, v); chk("R5 flags", v, 32'h4A0);

    // R8 R7 R9 counting in 16-bit mode
    ticks(5); rd(2'd1, v); chk("R8 count", v, 5);
    refresh16(); rd(2'd1, v); chk("R7 refresh16", v, 0);
    ticks(25); rd(2'd1, v); chk("R8 hold at timeout", v, 20);
    chk("R9 one pulse", pulses, 1);
    ticks(5); rd(2'd1, v); chk("R9 no repeat", pulses, 1);
    refresh16(); rd(2'd1, v); chk("R7 refresh16 after fire", v, 0);

    // R6 window expiry
    unlock16(); repeat (300) @(negedge clk);
    rd(2'd0, v); chk("R6 window closed", v, 32'hA0);
    wr(2'd2, 32'd7); rd(2'd2, v); chk("R6 late write ignored", v, 32'd20);

    // R4 R12 switch to 32-bit mode
    unlock16(); wr(2'd0, 32'h21A0);
    rd(2'd0, v); chk("R4 mode set", v, 32'h25A0);
    chk("R12 clk_sel", {30'b0, clk_sel}, 1);
    unlock16(); rd(2'd0, v); chk("R4 halves refused", v, 32'h25A0);
    wr(2'd1, 32'hD928_C520); rd(2'd0, v); chk("R4 unlock32", v, 32'h29A0);
    wr(2'd0, 32'h21A0);

    // R7 R8 R9 random runs, 32-bit refresh
    exp_p = pulses;
    for (int it = 0; it < 30; it++) begin
      wr(2'd1, 32'hB480_A602);
      k = $urandom % 30;
      ticks(k);
      if ($urandom % 3 == 0) wr(2'd1, $urandom | 32'h1);
      rd(2'd1, v); chk("R8 random run", v, exp_cnt(k, 20));
      if (k >= 20) exp_p++;
    end
    rd(2'd0, v);
    chk("R9 random pulses", pulses, exp_p);
    wr(2'd1, 32'hB480_A602); rd(2'd1, v); chk("R7 refresh32", v, 0);

    // R10 wait/stop gating
    sys_wait = 1'b1; ticks(5); rd(2'd1, v); chk("R10 wait gated", v, 0);
    wr(2'd1, 32'hD928_C520); wr(2'd0, 32'h21A2);
    ticks(5); rd(2'd1, v); chk("R10 wait allowed", v, 5);
    sys_wait = 1'b0; sys_stop = 1'b1;
    ticks(3); rd(2'd1, v); chk("R10 stop gated", v, 5);
    sys_stop = 1'b0;

    // R8 disable clears and freezes
    wr(2'd1, 32'hD928_C520); wr(2'd0, 32'h2120);
    ticks(3); rd(2'd1, v); chk("R8 disabled", v, 0);

    // R11 permanent lockout
    wr(2'd1, 32'hD928_C520); wr(2'd0, 32'h2100);
    rd(2'd0, v); chk("R11 applied", v, 32'h2500);
    wr(2'd1, 32'hD928_C520); rd(2'd0, v); chk("R11 unlock refused", v, 32'h2500);
    wr(2'd2, 32'd3); rd(2'd2, v); chk("R11 toval frozen", v, 32'd20);

    // R13 read timing: data appears the cycle after the strobe
    @(negedge clk); rd_en = 1'b1; addr = 2'd2;
    @(negedge clk); rd_en = 1'b0; addr = 2'd0;
    chk("R13 registered read", rdata, 32'd20);
    @(negedge clk); chk("R13 holds without strobe", rdata, 32'd20);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule